// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block holds the low-power state of an 8-bit microcontroller core. A small power-control register, written by the core, carries an idle request, a power-down request and two general-purpose flags. From that state the block produces three clock enables: one for the CPU, one for the peripherals and one for the oscillator. It also overrides the external bus pins. These are address latch enable, program store enable, and ports 0 to 3. The override depends on the mode and on whether code runs from internal or external program memory.

Idle stops only the CPU clock. An enabled interrupt ends it, and so does a qualified hardware reset. Power-down stops everything and ignores interrupts, so only the qualified reset ends it. The reset input must stay high for a configurable number of consecutive clock cycles (24 by default) before it acts. Shorter pulses have no effect.

On entry to either low-power mode the block freezes a copy of the four port data latches. It drives the pins from that copy until the mode ends, so the pins keep their state while the rest of the chip sleeps.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: A write with bit 0 set and bit 1 clear enters idle. In idle `cpu_clk_en` is 0 while `periph_clk_en` and `osc_en` stay 1.
- R2: A write with bit 1 set enters power-down, and this wins over bit 0. In power-down all three clock enables are 0 and the idle bit reads 0.
- R3: The same write loads bits 2 and 3 into flag 0 and flag 1. `pcon_rd` returns {4'b0, flag1, flag0, power-down, idle}, and the flags survive the exit from idle.
- R4: While in idle, `irq` high at a clock edge clears the idle bit at that edge, and the flags keep their values.
- R5: While in power-down, `irq` has no effect on the register or the clock enables.
- R6: `rst_in` high for RST_CYCLES consecutive edges clears all four register bits at the RST_CYCLES-th edge. A shorter pulse changes nothing.
- R7: `ale_o` and `psen_o` are 1 in idle and 0 in power-down. In normal mode they follow `core_ale` and `core_psen`.
- R8: In either low-power mode, `p0_oe` is 0 when `ext_mem` is 1, and 1 with `p0_o` driving the frozen port 0 latch when `ext_mem` is 0. In normal mode port 0 follows `core_p0_out` and `core_p0_oe`.
- R9: `p2_o` carries `core_p2_out` (the upper address byte) in normal mode and in idle with `ext_mem` at 1. Otherwise, in a low-power mode, it carries the frozen port 2 latch.
- R10: `p1_o` and `p3_o` follow their latch inputs in normal mode and drive the frozen latch values in both low-power modes.
- R11: The frozen copy holds the latch values present at the entry edge. Changes on the latch inputs during a low-power mode have no effect on the pins.
- R12: Register writes while in a low-power mode are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_in | input | 1 | Hardware reset request, active high, qualified by length |
| wr_en | input | 1 | Power-control register write strobe |
| wr_data | input | 8 | Write data: bit0 idle, bit1 power-down, bit2 flag0, bit3 flag1 |
| irq | input | 1 | Enabled interrupt request |
| ext_mem | input | 1 | 1 when code runs from external program memory |
| core_ale | input | 1 | Address latch enable from the core |
| core_psen | input | 1 | Program store enable from the core |
| core_p0_out | input | PW | Port 0 value from the core bus logic |
| core_p0_oe | input | 1 | Port 0 output enable from the core bus logic |
| core_p2_out | input | PW | Port 2 value from the core (upper address byte) |
| p0_lat | input | PW | Port 0 data latch |
| p1_lat | input | PW | Port 1 data latch |
| p2_lat | input | PW | Port 2 data latch |
| p3_lat | input | PW | Port 3 data latch |
| pcon_rd | output | 8 | Power-control register read value |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| ale_o | output | 1 | Address latch enable pin |
| psen_o | output | 1 | Program store enable pin |
| p0_o | output | PW | Port 0 pin value |
| p0_oe | output | 1 | Port 0 output enable |
| p1_o | output | PW | Port 1 pin value |
| p2_o | output | PW | Port 2 pin value |
| p3_o | output | PW | Port 3 pin value |

## Verification
Ending power-down is the hardest situation to reach. It needs a reset pulse held for at least RST_CYCLES edges while power-down is active, and the pulses just short of that length must be shown to leave the state alone. The stimulus uses directed sequences for these cases. It enters power-down, sends an interrupt, applies a short reset burst, changes the latch inputs and then applies a full-length burst. Random traffic then keeps power-down entries rare through biased write data and inserts reset bursts of random length, both below and above the threshold. Every output is compared each cycle against a reference model in the bench.

// File: rtl/pwr_mode_ctrl.sv
`timescale 1ns/1ps
module pwr_mode_ctrl #(
  parameter int PW         = 8,
  parameter int RST_CYCLES = 24
) (
  input  logic          clk,
  input  logic          rst_in,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          irq,
  input  logic          ext_mem,
  input  logic          core_ale,
  input  logic          core_psen,
  input  logic [PW-1:0] core_p0_out,
  input  logic          core_p0_oe,
  input  logic [PW-1:0] core_p2_out,
  input  logic [PW-1:0] p0_lat,
  input  logic [PW-1:0] p1_lat,
  input  logic [PW-1:0] p2_lat,
  input  logic [PW-1:0] p3_lat,
  output logic [7:0]    pcon_rd,
  output logic          cpu_clk_en,
  output logic          periph_clk_en,
  output logic          osc_en,
  output logic          ale_o,
  output logic          psen_o,
  output logic [PW-1:0] p0_o,
  output logic          p0_oe,
  output logic [PW-1:0] p1_o,
  output logic [PW-1:0] p2_o,
  output logic [PW-1:0] p3_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] rcnt;
  logic          rst_apply;
  logic          idl, pd, gf0, gf1, low;
  logic [PW-1:0] s0, s1, s2, s3;

  assign rst_apply = rst_in && (rcnt == CW'(RST_CYCLES - 1));
  assign low       = idl | pd;

  always_ff @(posedge clk) begin
    if (!rst_in)        rcnt <= '0;
    else if (!rst_apply) rcnt <= rcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_apply) begin
      idl <= 1'b0;
      pd  <= 1'b0;
      gf0 <= 1'b0;
      gf1 <= 1'b0;
    end else if (low) begin
      if (idl && !pd && irq) idl <= 1'b0;
    end else if (wr_en) begin
      pd  <= wr_data[1];
      idl <= wr_data[0] & ~wr_data[1];
      gf0 <= wr_data[2];
      gf1 <= wr_data[3];
    end
  end

  always_ff @(posedge clk) begin
    if (!low) begin
      s0 <= p0_lat;
      s1 <= p1_lat;
      s2 <= p2_lat;
      s3 <= p3_lat;
    end
  end

  assign pcon_rd       = {4'b0000, gf1, gf0, pd, idl};
  assign cpu_clk_en    = ~low;
  assign periph_clk_en = ~pd;
  assign osc_en        = ~pd;

  assign ale_o  = idl ? 1'b1 : pd ? 1'b0 : core_ale;
  assign psen_o = idl ? 1'b1 : pd ? 1'b0 : core_psen;

  assign p0_o  = low ? s0 : core_p0_out;
  assign p0_oe = low ? ~ext_mem : core_p0_oe;
  assign p1_o  = low ? s1 : p1_lat;
  assign p2_o  = !low ? core_p2_out : (idl && ext_mem) ? core_p2_out : s2;
  assign p3_o  = low ? s3 : p3_lat;
endmodule

module pwr_mode_ctrl_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_in,
  input logic          irq,
  input logic          wr_en,
  input logic          ext_mem,
  input logic [7:0]    pcon_rd,
  input logic          cpu_clk_en,
  input logic          periph_clk_en,
  input logic          osc_en,
  input logic          ale_o,
  input logic          psen_o,
  input logic          p0_oe,
  input logic [PW-1:0] p1_o
);
  assert_pd_stops_clocks_R2: assert property (@(posedge clk) disable iff (rst_in)
    pcon_rd[1] |-> (!osc_en && !cpu_clk_en && !periph_clk_en && !pcon_rd[0]));

  assert_idle_clocks_R1: assert property (@(posedge clk) disable iff (rst_in)
    pcon_rd[0] |-> (!cpu_clk_en && osc_en && periph_clk_en));

  assert_idle_wake_R4: assert property (@(posedge clk) disable iff (rst_in)
    (pcon_rd[0] && irq) |=> (!pcon_rd[0] && $stable(pcon_rd[3:2])));

  assert_pd_no_wake_R5: assert property (@(posedge clk) disable iff (rst_in)
    pcon_rd[1] |=> pcon_rd[1]);

  assert_pd_pins_low_R7: assert property (@(posedge clk) disable iff (rst_in)
    !osc_en |-> (!ale_o && !psen_o));

  assert_p0_float_R8: assert property (@(posedge clk) disable iff (rst_in)
    (!cpu_clk_en && ext_mem) |-> !p0_oe);

  assert_retain_R11: assert property (@(posedge clk) disable iff (rst_in)
    (!cpu_clk_en && $past(!cpu_clk_en)) |-> $stable(p1_o));

  assert_wr_ignored_R12: assert property (@(posedge clk) disable iff (rst_in)
    (!cpu_clk_en && wr_en && !irq) |=> $stable(pcon_rd));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_in(rst_in), .irq(irq), .wr_en(wr_en), .ext_mem(ext_mem),
  .pcon_rd(pcon_rd), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
  .osc_en(osc_en), .ale_o(ale_o), .psen_o(psen_o), .p0_oe(p0_oe), .p1_o(p1_o)
);

// File: tb/pwr_mode_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_bench;
  localparam int PW = 8;
  localparam int RC = 24;

  logic clk = 1'b0;
  logic rst_in = 1'b1, wr_en = 1'b0, irq = 1'b0, ext_mem = 1'b0;
  logic [7:0] wr_data = '0;
  logic core_ale = 1'b0, core_psen = 1'b0, core_p0_oe = 1'b0;
  logic [PW-1:0] core_p0_out = '0, core_p2_out = '0;
  logic [PW-1:0] p0_lat = '0, p1_lat = '0, p2_lat = '0, p3_lat = '0;
  logic [7:0] pcon_rd;
  logic cpu_clk_en, periph_clk_en, osc_en, ale_o, psen_o, p0_oe;
  logic [PW-1:0] p0_o, p1_o, p2_o, p3_o;

  pwr_mode_ctrl #(.PW(PW), .RST_CYCLES(RC)) u_pwr_mode_ctrl (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit armed = 0, done = 0;
  bit m_idl = 0, m_pd = 0, m_gf0 = 0, m_gf1 = 0;
  logic [PW-1:0] ms0 = '0, ms1 = '0, ms2 = '0, ms3 = '0;
  int m_rc = 0;

  task automatic chk(string ph, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", ph, what, act, exp);
    end
  endtask

  task automatic model_edge();
    bit low = m_idl | m_pd;
    bit apply = rst_in && (m_rc >= RC - 1);
    if (!low) begin ms0 = p0_lat; ms1 = p1_lat; ms2 = p2_lat; ms3 = p3_lat; end
    m_rc = rst_in ? ((m_rc < RC) ? m_rc + 1 : RC) : 0;
    if (apply) begin m_idl = 0; m_pd = 0; m_gf0 = 0; m_gf1 = 0; end
    else if (low) begin if (m_idl && irq) m_idl = 0; end
    else if (wr_en) begin
      m_pd = wr_data[1]; m_idl = wr_data[0] & ~wr_data[1];
      m_gf0 = wr_data[2]; m_gf1 = wr_data[3];
    end
  endtask

  function automatic logic [7:0] e_pcon();
    return {4'b0000, m_gf1, m_gf0, m_pd, m_idl};
  endfunction

  function automatic logic e_pin(logic core_v);
    return m_idl ? 1'b1 : m_pd ? 1'b0 : core_v;
  endfunction

  task automatic compare(string ph);
    bit low = m_idl | m_pd;
    chk(ph, "pcon_rd R3", pcon_rd, e_pcon());
    chk(ph, "cpu_clk_en R1", cpu_clk_en, !low);
    chk(ph, "periph_clk_en R2", periph_clk_en, !m_pd);
    chk(ph, "osc_en R2", osc_en, !m_pd);
    chk(ph, "ale_o R7", ale_o, e_pin(core_ale));
    chk(ph, "psen_o R7", psen_o, e_pin(core_psen));
    chk(ph, "p0_oe R8", p0_oe, low ? !ext_mem : core_p0_oe);
    chk(ph, "p0_o R8", p0_o, low ? ms0 : core_p0_out);
    chk(ph, "p2_o R9", p2_o, (!low || (m_idl && ext_mem)) ? core_p2_out : ms2);
    chk(ph, "p1_o R10", p1_o, low ? ms1 : p1_lat);
    chk(ph, "p3_o R10", p3_o, low ? ms3 : p3_lat);
  endtask

  task automatic cycle(string ph);
    @(posedge clk);
    model_edge();
    #1;
    if (armed) compare(ph);
    @(negedge clk);
    wr_en = 1'b0;
    irq = 1'b0;
  endtask

  task automatic write(string ph, logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    cycle(ph);
  endtask

  task automatic reset_burst(string ph, int len);
    rst_in = 1'b1;
    for (int k = 0; k < len; k++) cycle(ph);
    rst_in = 1'b0;
  endtask

  task automatic rnd_pins();
    core_ale = 1'($urandom); core_psen = 1'($urandom); core_p0_oe = 1'($urandom);
    core_p0_out = PW'($urandom); core_p2_out = PW'($urandom);
    p0_lat = PW'($urandom); p1_lat = PW'($urandom);
    p2_lat = PW'($urandom); p3_lat = PW'($urandom);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    reset_burst("init", RC + 6);
    armed = 1;
    cycle("reset state R6");

    rnd_pins();
    cycle("normal passthrough R10");
    write("enter idle with flags R1 R3", 8'h0D);
    ext_mem = 1'b1;
    cycle("idle external memory R8 R9");
    write("write ignored in idle R12", 8'h02);
    p1_lat = ~p1_lat; p3_lat = ~p3_lat;
    cycle("latches frozen in idle R11");
    irq = 1'b1;
    cycle("interrupt ends idle R4");
    cycle("flags kept after wake R3");

    rnd_pins();
    write("power-down wins over idle R2", 8'h07);
    irq = 1'b1;
    cycle("interrupt ignored in power-down R5");
    ext_mem = 1'b0;
    cycle("power-down internal memory R8 R9 R7");
    reset_burst("short reset ignored R6", RC - 1);
    cycle("still in power-down after short reset R6");
    rnd_pins();
    cycle("pins retained in power-down R11");
    ext_mem = 1'b1;
    cycle("power-down external memory R9");
    reset_burst("full reset exits power-down R6", RC);
    cycle("after full reset R6");

    begin
      int rb = 0;
      for (int i = 0; i < 4000; i++) begin
        rnd_pins();
        ext_mem = ($urandom % 8 == 0) ? ~ext_mem : ext_mem;
        if (rb > 0) begin rst_in = 1'b1; rb--; end
        else begin
          rst_in = 1'b0;
          if ($urandom % 120 == 0) rb = 3 + int'($urandom % 30);
        end
        irq = ($urandom % 6 == 0);
        if ($urandom % 5 == 0) begin
          wr_en = 1'b1;
          wr_data = 8'($urandom);
          if ($urandom % 4 != 0) wr_data[1] = 1'b0;
        end
        cycle("random R1 R2 R4 R5 R12");
      end
    end
    rst_in = 1'b0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R6 act=%h exp=%h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule